// File: doc/BRIEF.md
# Clock Output Enable Controller

This block is the digital control core of a clock buffer that has several differential output pairs and one single-ended reference output. It watches a combined power-good/power-down input. The first time that input goes high, the block captures two board straps and holds them from then on. The first strap picks one of two 7-bit bus addresses. The second is a three-level spread select, which the block turns into a 2-bit code. After that first assertion, a low level on the same input puts the device into power-down and a high level brings it back out.

For each differential pair the block decides whether the pair runs. A pair runs only when four things are true: its active-low pin enable is asserted, its register enable bit is set, the device is powered up, and the PLL has reported lock in the current power-up session. The block also reports the level a stopped pair parks at, and whether the reference output is tri-stated, stopped or running. The register bits arrive as plain inputs. The bus engine, PLL, oscillator and output drivers are outside this block.

Top module: `clkctl_top`

## Requirements
- R1: While `rst` is high and one cycle after it, the block shows `pair_run` = 0, `ref_mode` = 0 (tri-state), `strap_valid` = 0, `bus_addr` = 0, `ss_code` = 0 and `pwr_down` = 0.
- R2: The straps are captured on the first high level of `pg_pd` seen after reset, and `strap_valid` goes to 1 at that point. Later strap changes and later `pg_pd` toggles leave `bus_addr` and `ss_code` unchanged.
- R3: An address strap of 0 gives `bus_addr` = 7'b1101000. An address strap of 1 gives 7'b1101010.
- R4: `ss_strap` comes from a pad level detector: 2'b00 = low, 2'b11 = high, any other value = mid. The code is low → `ss_code` 2'b00 (spread off), mid → 2'b01 (-0.25%), high → 2'b10 (-0.5%). The value 2'b11 is never output.
- R5: Bit i of `pair_run` is 1 only when all of these hold: `oe_n[i]` = 0, `oe_reg[i]` = 1, `pg_pd` is high, and lock is held. A 1 on `oe_n[i]` disables the pair.
- R6: `pair_run` changes only on a clock edge where `phase_low` = 1. While `phase_low` = 0 it holds its value.
- R7: For every pair, `park_t` follows `stop_lvl[1]` and `park_c` follows `stop_lvl[0]`. The reset value is low/low.
- R8: `ref_mode` encodes 0 = tri-state, 1 = stopped, 2 = running. It stays 0 until the first high level of `pg_pd`, and it is 2 while powered up.
- R9: In power-down, `ref_mode` is 1 (stopped) when `ref_keep` = 0 and 2 (running) when `ref_keep` = 1.
- R10: Lock is sticky within a power-up session, so a drop of `pll_lock` does not stop running pairs. Entering power-down clears lock, and after the next power-up the pairs stay off until `pll_lock` rises again.
- R11: `pwr_down` is 1 exactly when the straps have been captured and `pg_pd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_pd | input | 1 | Power-good on first high level, power-down control afterwards (asynchronous) |
| addr_strap | input | 1 | Bus address select strap |
| ss_strap | input | 2 | Three-level spread strap from the pad detector |
| oe_n | input | NUM_PAIRS | Active-low pin enable per pair (asynchronous) |
| oe_reg | input | NUM_PAIRS | Register enable bit per pair |
| stop_lvl | input | 2 | Parked level of a stopped pair: [1] true leg, [0] complement leg |
| ref_keep | input | 1 | Keep the reference output running through power-down |
| pll_lock | input | 1 | PLL lock indication |
| phase_low | input | 1 | High while the output clock is in its low phase |
| pair_run | output | NUM_PAIRS | Per-pair run enable |
| park_t | output | NUM_PAIRS | Parked level of each true leg |
| park_c | output | NUM_PAIRS | Parked level of each complement leg |
| ref_mode | output | 2 | Reference output state |
| bus_addr | output | ADDR_W | Captured 7-bit bus address |
| ss_code | output | 2 | Captured spread code |
| strap_valid | output | 1 | Straps have been captured |
| pwr_down | output | 1 | Device is in power-down |

## Verification
The bench uses four pairs and two synchronizer stages. With these values the longest path from `pg_pd` to `pair_run` is four clock edges, so every expected value is sampled after an eight-cycle settling window. Four pairs are enough to mix pin and register enables in one step and to show the polarity of each. The bench resets the block several times with different strap values to reach all three spread codes and both addresses. Within one reset, it cycles power-down and power-up to check that the straps are held and that lock must be acquired again.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef enum logic [1:0] {
    REF_HIZ  = 2'd0,
    REF_STOP = 2'd1,
    REF_RUN  = 2'd2
  } ref_mode_e;

  typedef enum logic [1:0] {
    SS_OFF  = 2'd0,
    SS_QTR  = 2'd1,
    SS_HALF = 2'd2
  } ss_code_e;

  // pad detector: 00 low, 11 high, anything else mid
  function automatic ss_code_e decode_ss(input logic [1:0] lvl);
    ss_code_e code;
    case (lvl)
      2'b00:   code = SS_OFF;
      2'b11:   code = SS_HALF;
      default: code = SS_QTR;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/clkctl_sync.sv
module clkctl_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/clkctl_session.sv
module clkctl_session
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'b1101000,
  parameter int ADDR_SEL_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pg_s,
  input  logic              pll_lock,
  input  logic              addr_strap,
  input  logic [1:0]        ss_strap,
  input  logic              ref_keep,
  output logic              started,
  output logic              lock_q,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        ss_code,
  output logic              pwr_down,
  output logic [1:0]        ref_mode
);

  localparam logic [ADDR_W-1:0] SEL_MASK = ADDR_W'(1) << ADDR_SEL_BIT;

  ref_mode_e ref_nxt;

  always_comb begin
    if (!started)              ref_nxt = REF_HIZ;
    else if (pg_s || ref_keep) ref_nxt = REF_RUN;
    else                       ref_nxt = REF_STOP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started  <= 1'b0;
      bus_addr <= '0;
      ss_code  <= SS_OFF;
      lock_q   <= 1'b0;
      pwr_down <= 1'b0;
      ref_mode <= REF_HIZ;
    end else begin
      if (!started && pg_s) begin
        started  <= 1'b1;
        bus_addr <= addr_strap ? (ADDR_BASE | SEL_MASK) : ADDR_BASE;
        ss_code  <= decode_ss(ss_strap);
      end
      lock_q   <= pg_s && (lock_q || pll_lock);
      pwr_down <= started && !pg_s;
      ref_mode <= ref_nxt;
    end
  end

endmodule

// File: rtl/clkctl_pair_gate.sv
module clkctl_pair_gate (
  input  logic       clk,
  input  logic       rst,
  input  logic       oe_n_s,
  input  logic       oe_bit,
  input  logic       allow,
  input  logic       phase_low,
  input  logic [1:0] stop_lvl,
  output logic       run,
  output logic       park_t,
  output logic       park_c
);

  logic req;
  assign req = !oe_n_s && oe_bit && allow;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      park_t <= 1'b0;
      park_c <= 1'b0;
    end else begin
      if (phase_low) run <= req;
      park_t <= stop_lvl[1];
      park_c <= stop_lvl[0];
    end
  end

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top #(
  parameter int NUM_PAIRS = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'b1101000,
  parameter int ADDR_SEL_BIT = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pg_pd,
  input  logic                 addr_strap,
  input  logic [1:0]           ss_strap,
  input  logic [NUM_PAIRS-1:0] oe_n,
  input  logic [NUM_PAIRS-1:0] oe_reg,
  input  logic [1:0]           stop_lvl,
  input  logic                 ref_keep,
  input  logic                 pll_lock,
  input  logic                 phase_low,
  output logic [NUM_PAIRS-1:0] pair_run,
  output logic [NUM_PAIRS-1:0] park_t,
  output logic [NUM_PAIRS-1:0] park_c,
  output logic [1:0]           ref_mode,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [1:0]           ss_code,
  output logic                 strap_valid,
  output logic                 pwr_down
);

  logic                 pg_s;
  logic                 lock_q;
  logic [NUM_PAIRS-1:0] oe_n_s;
  logic                 allow;

  clkctl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk(clk), .rst(rst), .d(pg_pd), .q(pg_s)
  );

  clkctl_sync #(.WIDTH(NUM_PAIRS), .STAGES(SYNC_STAGES), .RST_VAL({NUM_PAIRS{1'b1}})) u_oe_sync (
    .clk(clk), .rst(rst), .d(oe_n), .q(oe_n_s)
  );

  clkctl_session #(.ADDR_W(ADDR_W), .ADDR_BASE(ADDR_BASE), .ADDR_SEL_BIT(ADDR_SEL_BIT)) u_session (
    .clk(clk), .rst(rst), .pg_s(pg_s), .pll_lock(pll_lock),
    .addr_strap(addr_strap), .ss_strap(ss_strap), .ref_keep(ref_keep),
    .started(strap_valid), .lock_q(lock_q), .bus_addr(bus_addr),
    .ss_code(ss_code), .pwr_down(pwr_down), .ref_mode(ref_mode)
  );

  assign allow = pg_s && lock_q;

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    clkctl_pair_gate u_gate (
      .clk(clk), .rst(rst), .oe_n_s(oe_n_s[i]), .oe_bit(oe_reg[i]),
      .allow(allow), .phase_low(phase_low), .stop_lvl(stop_lvl),
      .run(pair_run[i]), .park_t(park_t[i]), .park_c(park_c[i])
    );
  end

endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk #(
  parameter int NUM_PAIRS = 4,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'b1101000,
  parameter int ADDR_SEL_BIT = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 phase_low,
  input logic [NUM_PAIRS-1:0] pair_run,
  input logic [1:0]           ref_mode,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [1:0]           ss_code,
  input logic                 strap_valid,
  input logic                 pwr_down
);

  localparam logic [ADDR_W-1:0] SEL_MASK = ADDR_W'(1) << ADDR_SEL_BIT;

  // R6
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(phase_low)) |-> $stable(pair_run));

  // R8
  ref_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_mode != 2'd0) |-> strap_valid);

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strap_valid && $past(strap_valid)) |-> ($stable(bus_addr) && $stable(ss_code)));

  // R11
  pd_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> strap_valid);

  // R3
  addr_chk: assert property (@(posedge clk) disable iff (rst)
    strap_valid |-> (bus_addr == ADDR_BASE || bus_addr == (ADDR_BASE | SEL_MASK)));

  // R4
  ss_code_chk: assert property (@(posedge clk) disable iff (rst)
    ss_code != 2'b11);

endmodule

bind clkctl_top clkctl_chk #(
  .NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .ADDR_BASE(ADDR_BASE), .ADDR_SEL_BIT(ADDR_SEL_BIT)
) u_chk (
  .clk(clk), .rst(rst), .phase_low(phase_low), .pair_run(pair_run),
  .ref_mode(ref_mode), .bus_addr(bus_addr), .ss_code(ss_code),
  .strap_valid(strap_valid), .pwr_down(pwr_down)
);

// File: tb/test_clkctl_top.sv
module test_clkctl_top;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pg_pd = 1'b0;
  logic          addr_strap = 1'b1;
  logic [1:0]    ss_strap = 2'b11;
  logic [NP-1:0] oe_n = '0;
  logic [NP-1:0] oe_reg = '1;
  logic [1:0]    stop_lvl = 2'b00;
  logic          ref_keep = 1'b0;
  logic          pll_lock = 1'b0;
  logic          phase_low = 1'b1;
  logic [NP-1:0] pair_run, park_t, park_c;
  logic [1:0]    ref_mode, ss_code;
  logic [6:0]    bus_addr;
  logic          strap_valid, pwr_down;

  always #2 clk = ~clk;

  clkctl_top #(.NUM_PAIRS(NP), .SYNC_STAGES(2)) i_clkctl_top (
    .clk(clk), .rst(rst), .pg_pd(pg_pd), .addr_strap(addr_strap), .ss_strap(ss_strap),
    .oe_n(oe_n), .oe_reg(oe_reg), .stop_lvl(stop_lvl), .ref_keep(ref_keep),
    .pll_lock(pll_lock), .phase_low(phase_low), .pair_run(pair_run), .park_t(park_t),
    .park_c(park_c), .ref_mode(ref_mode), .bus_addr(bus_addr), .ss_code(ss_code),
    .strap_valid(strap_valid), .pwr_down(pwr_down)
  );

  typedef struct {
    logic [NP-1:0] run, pt, pc;
    logic [1:0]    rm;
    logic [6:0]    addr;
    logic [1:0]    ss;
    logic          valid, pd;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // monitor: compares each queued expectation against the ports
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [34:0] act, expv;
        e = exp_q.pop_front();
        act  = {pair_run, park_t, park_c, ref_mode, bus_addr, ss_code, strap_valid, pwr_down};
        expv = {e.run, e.pt, e.pc, e.rm, e.addr, e.ss, e.valid, e.pd};
        checks++;
        if (act !== expv) begin
          errors++;
          $display("FAIL %s actual run=%b pt=%b pc=%b ref=%0d addr=%b ss=%b valid=%b pd=%b expected run=%b pt=%b pc=%b ref=%0d addr=%b ss=%b valid=%b pd=%b",
                   e.tag, pair_run, park_t, park_c, ref_mode, bus_addr, ss_code, strap_valid, pwr_down,
                   e.run, e.pt, e.pc, e.rm, e.addr, e.ss, e.valid, e.pd);
        end
      end
    end
  end

  task automatic expect_after(input int wait_cyc, input logic [NP-1:0] run,
                              input logic [NP-1:0] pt, input logic [NP-1:0] pc,
                              input logic [1:0] rm, input logic [6:0] addr,
                              input logic [1:0] ss, input logic valid, input logic pd,
                              input string tag);
    exp_t e;
    repeat (wait_cyc) @(negedge clk);
    e.run = run; e.pt = pt; e.pc = pc; e.rm = rm; e.addr = addr;
    e.ss = ss; e.valid = valid; e.pd = pd; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic restart(input logic a, input logic [1:0] s);
    @(negedge clk);
    rst = 1'b1; pg_pd = 1'b0; pll_lock = 1'b0; ref_keep = 1'b0;
    oe_n = '0; oe_reg = '1; stop_lvl = 2'b00; phase_low = 1'b1;
    addr_strap = a; ss_strap = s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // R1 / R8: reset state, then still tri-stated while pg_pd stays low
    repeat (3) @(negedge clk);
    exp_q.push_back('{run:'0, pt:'0, pc:'0, rm:2'd0, addr:7'd0, ss:2'd0, valid:1'b0, pd:1'b0, tag:"R1 reset state"});
    rst = 1'b0;
    expect_after(8, '0, '0, '0, 2'd0, 7'd0, 2'd0, 1'b0, 1'b0, "R8 hiz before first power-good");

    // R2 R3 R4: first power-good captures address 1, spread high; R5 blocked without lock
    pg_pd = 1'b1;
    expect_after(8, '0, '0, '0, 2'd2, 7'b1101010, 2'b10, 1'b1, 1'b0, "R2 R3 R4 capture, R5 no lock");

    pll_lock = 1'b1;
    expect_after(8, 4'b1111, '0, '0, 2'd2, 7'b1101010, 2'b10, 1'b1, 1'b0, "R5 all pairs run");

    oe_n = 4'b0101; oe_reg = 4'b1110;
    expect_after(8, 4'b1010, '0, '0, 2'd2, 7'b1101010, 2'b10, 1'b1, 1'b0, "R5 pin and register enables");

    phase_low = 1'b0; oe_n = 4'b0000;
    expect_after(8, 4'b1010, '0, '0, 2'd2, 7'b1101010, 2'b10, 1'b1, 1'b0, "R6 hold outside low phase");

    phase_low = 1'b1;
    expect_after(8, 4'b1110, '0, '0, 2'd2, 7'b1101010, 2'b10, 1'b1, 1'b0, "R6 update in low phase");

    stop_lvl = 2'b10;
    expect_after(8, 4'b1110, 4'b1111, 4'b0000, 2'd2, 7'b1101010, 2'b10, 1'b1, 1'b0, "R7 park levels true high");

    pll_lock = 1'b0;
    expect_after(8, 4'b1110, 4'b1111, 4'b0000, 2'd2, 7'b1101010, 2'b10, 1'b1, 1'b0, "R10 lock sticky");

    pg_pd = 1'b0;
    expect_after(8, 4'b0000, 4'b1111, 4'b0000, 2'd1, 7'b1101010, 2'b10, 1'b1, 1'b1, "R9 R11 power-down ref stopped");

    ref_keep = 1'b1; stop_lvl = 2'b01;
    expect_after(8, 4'b0000, 4'b0000, 4'b1111, 2'd2, 7'b1101010, 2'b10, 1'b1, 1'b1, "R9 keep-alive, R7 comp high");

    addr_strap = 1'b0; ss_strap = 2'b01; pg_pd = 1'b1;
    expect_after(8, 4'b0000, 4'b0000, 4'b1111, 2'd2, 7'b1101010, 2'b10, 1'b1, 1'b0, "R2 straps held, R10 relock needed");

    pll_lock = 1'b1;
    expect_after(8, 4'b1110, 4'b0000, 4'b1111, 2'd2, 7'b1101010, 2'b10, 1'b1, 1'b0, "R10 relocked");

    oe_n = 4'b1111; oe_reg = 4'b1111;
    expect_after(8, 4'b0000, 4'b0000, 4'b1111, 2'd2, 7'b1101010, 2'b10, 1'b1, 1'b0, "R5 pin high disables");

    // R3 R4: address 0, spread mid
    restart(1'b0, 2'b01);
    pg_pd = 1'b1;
    expect_after(8, '0, '0, '0, 2'd2, 7'b1101000, 2'b01, 1'b1, 1'b0, "R3 R4 addr low spread mid");

    // R4: other mid encoding and spread off
    restart(1'b0, 2'b10);
    pg_pd = 1'b1;
    expect_after(8, '0, '0, '0, 2'd2, 7'b1101000, 2'b01, 1'b1, 1'b0, "R4 detector 10 is mid");

    restart(1'b1, 2'b00);
    pg_pd = 1'b1;
    expect_after(8, '0, '0, '0, 2'd2, 7'b1101010, 2'b00, 1'b1, 1'b0, "R4 spread off");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule